// File: doc/BRIEF.md
# Framed Preamble and Text Message Bit Source

This block feeds a QPSK transmitter with a never-ending serial stream of 200-bit frames, one bit per accepted handshake. Every frame opens with a 26-bit preamble that is sent in the clear. The preamble carries the 13-chip Barker pattern, one chip per bit pair, so both bits of a QPSK symbol carry the same chip. A 174-bit payload follows the preamble. Its first 105 bits spell a 15-character text line in 7-bit ASCII. The line ends in a three-digit decimal frame number. The remaining 69 payload bits are pseudo-random filler.

The whole payload is XORed with an additive scrambler key so that the receiver sees balanced ones and zeros. The scrambler restarts from a fixed seed in every frame, so any single frame can be descrambled without the frames before it. A downstream symbol mapper pulls bits with `outReady`. The block marks the first preamble bit of each frame with `outSof`. A synchronous reset restarts the frame number at 001 and returns both pseudo-random generators to their seeds.

Top module: `frame_bitgen`

## Requirements
- R1: In the first cycle after reset is released, `outValid` is 1, `outSof` is 1 and `outBit` carries the first preamble bit. The first frame after any reset carries the frame number 001.
- R2: A frame is 200 accepted bits long. `outSof` is 1 only while the first bit of a frame is presented, so exactly one accepted bit in each 200 has it set.
- R3: Frame bits 0 to 25 are unscrambled pairs. Chip k (k = 0..12) sits in bits 2k and 2k+1. The chip order is +1 +1 +1 +1 +1 −1 −1 +1 +1 −1 +1 −1 +1, and a +1 chip is sent as 11 while a −1 chip is sent as 00.
- R4: Before scrambling, frame bits 26 to 130 hold the 15 characters `Hello world ` followed by three decimal digits. Each character is sent as its 7-bit ASCII code with the most significant bit first, in text order, and the digits are coded 0x30 to 0x39.
- R5: The frame number counts 001, 002, …, 099 and then returns to 001. It is never 000, and it steps once per completed frame.
- R6: Before scrambling, frame bits 131 to 199 come from a 7-bit generator f with seed 0x7F. The filler bit is f[6]^f[5], and after each accepted filler bit f becomes {f[5:0], f[6]^f[5]}. The generator runs on from frame to frame and is reseeded only by reset.
- R7: Each payload bit (frame bits 26 to 199) is XORed with the key s[4]^s[3] of a 5-bit scrambler s. The scrambler holds 0x1F at the first payload bit of every frame, and after each accepted payload bit s becomes {s[3:0], s[4]^s[3]}.
- R8: While `outValid` is 1 and `outReady` is 0, `outBit`, `outSof` and `outValid` keep their values on the next cycle, and no part of the stream advances.
- R9: Outside reset, `outValid` stays at 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| outReady | input | 1 | Consumer accepts the presented bit at the next rising edge |
| outValid | output | 1 | A bit is presented |
| outBit | output | 1 | Current stream bit |
| outSof | output | 1 | Presented bit is the first bit of a frame |

## Verification
`outBit` and `outSof` are decoded combinationally from registered state, so the bit shown in a cycle is the one that the next rising edge with `outReady` high consumes. The following bit appears right after that edge. Reset leaves `outValid` low until the first edge with reset deasserted, and the preamble start is shown from that point. The bench drives `outReady` and samples every output on the falling edge. It advances its own frame model only after an edge at which it drove `outReady` high, so each comparison lines up with exactly the bit the design should be presenting in that cycle. Stall cycles are compared against the unchanged model.

// File: rtl/frame_pkg.sv
package frame_pkg;

  // Strobes handed from the frame sequencer to the bit datapath
  typedef struct packed {
    logic sof;     // presenting bit 0 of a frame
    logic inHdr;   // presenting a preamble bit
    logic inMsg;   // presenting a text bit
    logic inFill;  // presenting a filler bit
    logic step;    // presented bit is taken at this edge
    logic last;    // presented bit is the last of the frame
  } frameStrb_t;

endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_pkg::*;
#(
  parameter int FRAME_BITS = 200,
  parameter int HDR_BITS   = 26,
  parameter int MSG_CHARS  = 15,
  parameter int CHAR_BITS  = 7,
  parameter int NUM_DIGITS = 3,
  parameter int INDEX_MAX  = 99,
  localparam int POS_W     = $clog2(FRAME_BITS),
  localparam int CHAR_W    = $clog2(MSG_CHARS + 1),
  localparam int BIT_W     = $clog2(CHAR_BITS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        outReady,
  output logic                        outValid,
  output frameStrb_t                  strb,
  output logic [POS_W-1:0]            pos,
  output logic [CHAR_W-1:0]           charIdx,
  output logic [BIT_W-1:0]            bitIdx,
  output logic [NUM_DIGITS-1:0][3:0]  digits
);

  localparam int MSG_END = HDR_BITS + MSG_CHARS * CHAR_BITS;
  localparam int IDX_W   = $clog2(INDEX_MAX + 1);
  localparam logic [NUM_DIGITS*4-1:0] DIG_ONE = (NUM_DIGITS*4)'(1);

  logic                       validQ;
  logic [POS_W-1:0]           posQ;
  logic [CHAR_W-1:0]          chQ;
  logic [BIT_W-1:0]           bitQ;
  logic [IDX_W-1:0]           idxQ;
  logic [NUM_DIGITS-1:0][3:0] digQ;
  logic [NUM_DIGITS-1:0][3:0] digNext;

  // Decode of the bit position into frame regions
  always_comb begin
    strb.sof    = (posQ == '0);
    strb.inHdr  = (int'(posQ) < HDR_BITS);
    strb.inMsg  = (int'(posQ) >= HDR_BITS) && (int'(posQ) < MSG_END);
    strb.inFill = (int'(posQ) >= MSG_END);
    strb.step   = validQ && outReady;
    strb.last   = (posQ == POS_W'(FRAME_BITS - 1));
  end

  // Decimal ripple increment of the frame number digits
  always_comb begin
    logic carry;
    carry = 1'b1;
    for (int d = 0; d < NUM_DIGITS; d++) begin
      digNext[d] = digQ[d];
      if (carry) begin
        if (digQ[d] == 4'd9) begin
          digNext[d] = 4'd0;
        end else begin
          digNext[d] = digQ[d] + 4'd1;
          carry      = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= 1'b0;
      posQ   <= '0;
      chQ    <= '0;
      bitQ   <= '0;
      idxQ   <= IDX_W'(1);
      digQ   <= DIG_ONE;
    end else begin
      validQ <= 1'b1;
      if (strb.step) begin
        if (strb.last) begin
          posQ <= '0;
          chQ  <= '0;
          bitQ <= '0;
          if (idxQ == IDX_W'(INDEX_MAX)) begin
            idxQ <= IDX_W'(1);
            digQ <= DIG_ONE;
          end else begin
            idxQ <= idxQ + IDX_W'(1);
            digQ <= digNext;
          end
        end else begin
          posQ <= posQ + POS_W'(1);
          if (strb.inMsg) begin
            if (bitQ == BIT_W'(CHAR_BITS - 1)) begin
              bitQ <= '0;
              chQ  <= chQ + CHAR_W'(1);
            end else begin
              bitQ <= bitQ + BIT_W'(1);
            end
          end
        end
      end
    end
  end

  assign outValid = validQ;
  assign pos      = posQ;
  assign charIdx  = chQ;
  assign bitIdx   = bitQ;
  assign digits   = digQ;

  // R5
  idx_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    idxQ != '0);

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digChk
    // R5
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      digQ[d] <= 4'd9);
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    validQ && !outReady |=> $stable(posQ) && $stable(chQ) && $stable(bitQ) && $stable(idxQ));

  // R2
  sof_single_chk: assert property (@(posedge clk) disable iff (rst)
    strb.sof && strb.step |=> !strb.sof);

endmodule

// File: rtl/frame_datapath.sv
module frame_datapath
  import frame_pkg::*;
#(
  parameter int FRAME_BITS = 200,
  parameter int HDR_BITS   = 26,
  parameter int MSG_CHARS  = 15,
  parameter int CHAR_BITS  = 7,
  parameter int NUM_DIGITS = 3,
  parameter logic [HDR_BITS/2-1:0] PREAMBLE = 13'b1111100110101,
  parameter logic [6:0] FILL_SEED = 7'h7F,
  parameter logic [4:0] SCR_SEED  = 5'h1F,
  localparam int POS_W  = $clog2(FRAME_BITS),
  localparam int CHAR_W = $clog2(MSG_CHARS + 1),
  localparam int BIT_W  = $clog2(CHAR_BITS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  frameStrb_t                  strb,
  input  logic [POS_W-1:0]            pos,
  input  logic [CHAR_W-1:0]           charIdx,
  input  logic [BIT_W-1:0]            bitIdx,
  input  logic [NUM_DIGITS-1:0][3:0]  digits,
  output logic                        dataBit
);

  localparam int CHIPS  = HDR_BITS / 2;
  localparam int CHIP_W = $clog2(CHIPS);
  localparam int DIG_W  = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam int FIXED  = MSG_CHARS - NUM_DIGITS;

  logic [6:0]           fillQ;
  logic [4:0]           scrQ;
  logic [CHIP_W-1:0]    chipSel;
  logic [CHAR_BITS-1:0] code;
  logic                 hdrBit;
  logic                 msgBit;
  logic                 fillBit;
  logic                 scrKey;
  logic                 payRaw;

  // Fixed part of the text line, then the frame number digits
  function automatic logic [CHAR_BITS-1:0] textChar(
    input logic [CHAR_W-1:0]          c,
    input logic [NUM_DIGITS-1:0][3:0] dg
  );
    logic [DIG_W-1:0] dSel;
    if (int'(c) >= FIXED) begin
      dSel = DIG_W'(MSG_CHARS - 1 - int'(c));
      return CHAR_BITS'(8'h30) | CHAR_BITS'(dg[dSel]);
    end
    case (c)
      CHAR_W'(0):  return CHAR_BITS'(8'h48);
      CHAR_W'(1):  return CHAR_BITS'(8'h65);
      CHAR_W'(2):  return CHAR_BITS'(8'h6C);
      CHAR_W'(3):  return CHAR_BITS'(8'h6C);
      CHAR_W'(4):  return CHAR_BITS'(8'h6F);
      CHAR_W'(6):  return CHAR_BITS'(8'h77);
      CHAR_W'(7):  return CHAR_BITS'(8'h6F);
      CHAR_W'(8):  return CHAR_BITS'(8'h72);
      CHAR_W'(9):  return CHAR_BITS'(8'h6C);
      CHAR_W'(10): return CHAR_BITS'(8'h64);
      default:     return CHAR_BITS'(8'h20);
    endcase
  endfunction

  always_comb begin
    chipSel = CHIP_W'(CHIPS - 1) - CHIP_W'(pos >> 1);
    hdrBit  = PREAMBLE[chipSel];
    code    = textChar(charIdx, digits);
    msgBit  = code[BIT_W'(CHAR_BITS - 1) - bitIdx];
    fillBit = fillQ[6] ^ fillQ[5];
    scrKey  = scrQ[4] ^ scrQ[3];
    payRaw  = strb.inMsg ? msgBit : fillBit;
    dataBit = strb.inHdr ? hdrBit : (payRaw ^ scrKey);
  end

  // Filler generator, steps on taken filler bits only
  always_ff @(posedge clk) begin
    if (rst) begin
      fillQ <= FILL_SEED;
    end else if (strb.step && strb.inFill) begin
      fillQ <= {fillQ[5:0], fillQ[6] ^ fillQ[5]};
    end
  end

  // Payload scrambler, reseeded as each frame closes
  always_ff @(posedge clk) begin
    if (rst) begin
      scrQ <= SCR_SEED;
    end else if (strb.step) begin
      if (strb.last) begin
        scrQ <= SCR_SEED;
      end else if (!strb.inHdr) begin
        scrQ <= {scrQ[3:0], scrQ[4] ^ scrQ[3]};
      end
    end
  end

  // R7
  scr_seed_at_sof_chk: assert property (@(posedge clk) disable iff (rst)
    strb.sof |-> scrQ == SCR_SEED);

  // R6
  fill_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    fillQ != '0);

  // R6
  fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.inFill |=> $stable(fillQ));

endmodule

// File: rtl/frame_bitgen.sv
module frame_bitgen
  import frame_pkg::*;
#(
  parameter int FRAME_BITS = 200,
  parameter int HDR_BITS   = 26,
  parameter int MSG_CHARS  = 15,
  parameter int CHAR_BITS  = 7,
  parameter int NUM_DIGITS = 3,
  parameter int INDEX_MAX  = 99
) (
  input  logic clk,
  input  logic rst,
  input  logic outReady,
  output logic outValid,
  output logic outBit,
  output logic outSof
);

  localparam int POS_W  = $clog2(FRAME_BITS);
  localparam int CHAR_W = $clog2(MSG_CHARS + 1);
  localparam int BIT_W  = $clog2(CHAR_BITS);

  frameStrb_t                 strb;
  logic [POS_W-1:0]           pos;
  logic [CHAR_W-1:0]          charIdx;
  logic [BIT_W-1:0]           bitIdx;
  logic [NUM_DIGITS-1:0][3:0] digits;
  logic                       validInt;

  frame_ctrl #(
    .FRAME_BITS(FRAME_BITS), .HDR_BITS(HDR_BITS), .MSG_CHARS(MSG_CHARS),
    .CHAR_BITS(CHAR_BITS), .NUM_DIGITS(NUM_DIGITS), .INDEX_MAX(INDEX_MAX)
  ) u_ctrl (
    .clk(clk), .rst(rst), .outReady(outReady), .outValid(validInt),
    .strb(strb), .pos(pos), .charIdx(charIdx), .bitIdx(bitIdx), .digits(digits)
  );

  frame_datapath #(
    .FRAME_BITS(FRAME_BITS), .HDR_BITS(HDR_BITS), .MSG_CHARS(MSG_CHARS),
    .CHAR_BITS(CHAR_BITS), .NUM_DIGITS(NUM_DIGITS)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .pos(pos), .charIdx(charIdx),
    .bitIdx(bitIdx), .digits(digits), .dataBit(outBit)
  );

  assign outValid = validInt;
  assign outSof   = validInt && strb.sof;

  // R8
  port_stall_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outBit) && $stable(outSof));

  // R9
  valid_high_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> outValid);

endmodule

// File: tb/frame_bitgen_tb.sv
`timescale 1ns/1ps
module frame_bitgen_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic outReady = 1'b0;
  logic outValid, outBit, outSof;

  always #5 clk = ~clk;

  frame_bitgen u_dut (
    .clk(clk), .rst(rst), .outReady(outReady),
    .outValid(outValid), .outBit(outBit), .outSof(outSof)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Bench frame model, built from the requirements
  localparam bit [12:0] CHIP_SEQ = 13'b1111100110101;
  int         mPos;
  int         mIdx;
  logic [6:0] mFill;
  logic [4:0] mScr;
  int         sofCount;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic expBit();
    int p;
    string s;
    byte ch;
    logic raw;
    if (mPos < 26) return CHIP_SEQ[12 - mPos / 2];
    p = mPos - 26;
    if (p < 105) begin
      s   = $sformatf("Hello world %03d", mIdx);
      ch  = s[p / 7];
      raw = ch[6 - (p % 7)];
    end else begin
      raw = mFill[6] ^ mFill[5];
    end
    return raw ^ (mScr[4] ^ mScr[3]);
  endfunction

  function automatic string regionTag();
    if (mPos < 26) return "R3 preamble";
    if (mPos < 131) return "R4 R5 R7 text";
    return "R6 R7 filler";
  endfunction

  task automatic modelReset();
    mPos  = 0;
    mIdx  = 1;
    mFill = 7'h7F;
    mScr  = 5'h1F;
  endtask

  task automatic modelStep();
    if (mPos >= 131) mFill = {mFill[5:0], mFill[6] ^ mFill[5]};
    if (mPos >= 26)  mScr  = {mScr[3:0], mScr[4] ^ mScr[3]};
    if (mPos == 199) begin
      mPos = 0;
      mScr = 5'h1F;
      mIdx = (mIdx == 99) ? 1 : mIdx + 1;
    end else begin
      mPos++;
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    outReady = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    modelReset();
  endtask

  // R1: state right after reset release
  task automatic checkReset();
    check(outValid === 1'b1, "R1", "valid after reset", int'(outValid), 1);
    check(outSof === 1'b1, "R1", "sof after reset", int'(outSof), 1);
    check(outBit === 1'b1, "R1", "first preamble bit", int'(outBit), 1);
  endtask

  // Streams n accepted bits; ready drops one cycle in every stallEvery
  task automatic streamBits(input int n, input int stallEvery);
    int cyc = 0;
    for (int i = 0; i < n; ) begin
      logic r;
      @(negedge clk);
      check(outValid === 1'b1, "R9", "valid in stream", int'(outValid), 1);
      check(outSof === (mPos == 0), "R2", "sof position", int'(outSof), int'(mPos == 0));
      check(outBit === expBit(), regionTag(), $sformatf("bit at pos %0d idx %0d", mPos, mIdx),
            int'(outBit), int'(expBit()));
      r = (stallEvery == 0) || ((cyc % stallEvery) != stallEvery - 1);
      cyc++;
      outReady = r;
      @(posedge clk);
      if (r) begin
        if (mPos == 0) sofCount++;
        modelStep();
        i++;
      end
    end
  endtask

  // R8: outputs frozen while ready is low, stream resumes at the same bit
  task automatic stallTest();
    logic hb, hs;
    @(negedge clk);
    hb = outBit;
    hs = outSof;
    outReady = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(outBit === hb, "R8", "bit held in stall", int'(outBit), int'(hb));
      check(outSof === hs, "R8", "sof held in stall", int'(outSof), int'(hs));
      check(outValid === 1'b1, "R8", "valid held in stall", int'(outValid), 1);
    end
    streamBits(60, 0);
  endtask

  // R5 R2: run past frame 99 so the number wraps to 001
  task automatic wrapTest();
    applyReset();
    checkReset();
    sofCount = 0;
    streamBits(101 * 200, 0);
    check(sofCount == 101, "R2 R5", "frames counted", sofCount, 101);
  endtask

  // R1: reset in the middle of the text restarts frame and number
  task automatic midReset();
    streamBits(77, 0);
    applyReset();
    checkReset();
    streamBits(200, 0);
  endtask

  initial begin
    modelReset();
    sofCount = 0;
    applyReset();
    checkReset();
    streamBits(400, 0);
    check(sofCount == 2, "R2", "two frames", sofCount, 2);
    streamBits(30, 0);
    stallTest();
    streamBits(600, 3);
    midReset();
    wrapTest();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule